// File: doc/BRIEF.md
# Strongly Ordered Access Serializer

This block sits between a load/store issue stage and the memory bus. Every access arrives with a per-page tag from translation that says whether it must be strongly ordered. Untagged accesses pass straight through to the bus. A tagged access must wait until every earlier access has completed. Once it is issued, it holds back every other access until its own completion returns. Its completion can be a write response, returned read data or an error response.

Two requests from elsewhere in the pipeline also depend on that completion. A memory barrier request is answered with a one-cycle done pulse, but only when nothing is outstanding. An instruction that updates the interrupt masks is stalled while a tagged access is in flight.

The request and bus interfaces use valid/ready handshakes. A transfer occurs on a cycle where both valid and ready are high. The requester must keep its request stable until it is accepted. The bus may hold `bus_ready` low for any length of time. `req_ready` is `bus_ready` gated by the ordering decision, so back-pressure flows straight from the bus to the requester with no buffering in between. Responses are single-cycle pulses with no ready signal.

Top module: `strict_order_gate`

## Requirements
- R1: After reset the block holds no outstanding accesses and no tagged access in flight. `bar_done`, `irqm_stall`, `ord_stall` and `so_err` are low. An asynchronous reset in mid-operation releases any fence at once.
- R2: An untagged request with no fence active appears on the bus in the same cycle. Its address, size, beat count, direction, cacheable bit and shared bit are unchanged, and `req_ready` equals `bus_ready`.
- R3: A tagged request is held while any access is outstanding. While held, `bus_valid` and `req_ready` are low and `ord_stall` is high.
- R4: While a tagged access is in flight, every request is held, tagged or not.
- R5: A single response (`rsp_valid`) completes the tagged access in flight. Requests may issue from the next cycle onward.
- R6: With `bar_req` held high, `bar_done` pulses for exactly one cycle, and only in a cycle with no outstanding access and no tagged access in flight. It pulses at most once per request. The requester drops `bar_req` after the pulse.
- R7: `irqm_stall` is high exactly when `irqm_req` is high and a tagged access is in flight.
- R8: A tagged access is sent as one bus transaction, with the requested size (`2**size` bytes per beat) and beat count. `bus_valid` stays low from the cycle after its acceptance until its response, so it is never replayed.
- R9: On the bus, a tagged access carries cacheable = 0 and shared = 1, whatever its input tags.
- R10: `page_xing` pulses in the acceptance cycle of a tagged request with more than one beat whose byte span `beats << size`, starting at `req_addr`, crosses a 4 KB page boundary. It stays low for single-beat, non-crossing and untagged requests.
- R11: An error response (`rsp_err` with `rsp_valid`) to a tagged access completes it like a normal response and pulses `so_err` in that same cycle.
- R12: An untagged request is held while the outstanding counter is at its maximum, `2**CW - 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | AW | Byte address |
| req_size | input | SW | Log2 of bytes per beat |
| req_beats | input | BW | Beats in the transaction |
| req_write | input | 1 | 1 = write, 0 = read |
| req_strict | input | 1 | Strongly ordered page tag |
| req_cacheable | input | 1 | Cacheable page tag |
| req_shared | input | 1 | Shared page tag |
| bus_valid | output | 1 | Bus request present |
| bus_ready | input | 1 | Bus accepts request |
| bus_addr | output | AW | Bus address |
| bus_size | output | SW | Bus beat size |
| bus_beats | output | BW | Bus beat count |
| bus_write | output | 1 | Bus direction |
| bus_cacheable | output | 1 | Bus cacheable attribute |
| bus_shared | output | 1 | Bus shared attribute |
| rsp_valid | input | 1 | Completion of the oldest outstanding access |
| rsp_err | input | 1 | Completion carries an error |
| bar_req | input | 1 | Barrier waiting for completion |
| bar_done | output | 1 | One-cycle barrier completion |
| irqm_req | input | 1 | Interrupt-mask update waiting |
| irqm_stall | output | 1 | Hold the interrupt-mask update |
| ord_stall | output | 1 | Request held by ordering rules |
| so_err | output | 1 | Tagged access ended in error |
| page_xing | output | 1 | Tagged multi-beat request crosses 4 KB |

## Verification
The assertions assume the bus never returns `rsp_valid` while nothing is outstanding. They also assume that a request, once presented, keeps its tags stable until accepted, and that `bar_req` falls after its done pulse. The vectors and directed tests send responses only against issued accesses. They change request fields only after a handshake or while `req_valid` is low, and they release the barrier right after the pulse. Under these conditions the fence, barrier and counter behaviour seen at the ports follows from the requirements alone.

// File: rtl/so_pkg.sv
package so_pkg;
  localparam int PAGE_BITS = 12;

  typedef enum logic [1:0] {
    GATE_OPEN   = 2'd0,
    GATE_DRAIN  = 2'd1,
    GATE_FENCED = 2'd2,
    GATE_FULL   = 2'd3
  } gate_e;
endpackage

// File: rtl/so_track.sv
module so_track #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          issue_strict,
  input  logic          rsp_valid,
  output logic [CW-1:0] cnt,
  output logic          busy,
  output logic          cnt_zero,
  output logic          cnt_full
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] ONE     = {{(CW-1){1'b0}}, 1'b1};

  logic rsp_ok;
  assign rsp_ok   = rsp_valid && (cnt != '0);
  assign cnt_zero = (cnt == '0);
  assign cnt_full = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else begin
      case ({issue, rsp_ok})
        2'b10:   cnt <= cnt + ONE;
        2'b01:   cnt <= cnt - ONE;
        default: cnt <= cnt;
      endcase
      if (issue && issue_strict) busy <= 1'b1;
      else if (busy && rsp_ok)   busy <= 1'b0;
    end
  end
endmodule

// File: rtl/so_gate.sv
module so_gate
  import so_pkg::*;
(
  input  logic  req_strict,
  input  logic  busy,
  input  logic  cnt_zero,
  input  logic  cnt_full,
  output gate_e state
);
  always_comb begin
    if (busy)            state = GATE_FENCED;
    else if (req_strict) state = cnt_zero ? GATE_OPEN : GATE_DRAIN;
    else                 state = cnt_full ? GATE_FULL : GATE_OPEN;
  end
endmodule

// File: rtl/so_page_xing.sv
module so_page_xing
  import so_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 3,
  parameter int BW = 4
) (
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] size,
  input  logic [BW-1:0] beats,
  output logic          xing
);
  localparam int XW = AW + 1;

  logic [XW-1:0] span;
  logic [XW-1:0] last;
  logic          multi;

  assign multi = (beats > {{(BW-1){1'b0}}, 1'b1});
  assign span  = {{(XW-BW){1'b0}}, beats} << size;
  assign last  = {1'b0, addr} + span - {{(XW-1){1'b0}}, 1'b1};
  assign xing  = multi && (last[XW-1:PAGE_BITS] != {1'b0, addr[AW-1:PAGE_BITS]});
endmodule

// File: rtl/so_barrier.sv
module so_barrier (
  input  logic clk,
  input  logic rst_n,
  input  logic bar_req,
  input  logic idle,
  output logic bar_done
);
  logic served;

  assign bar_done = bar_req && idle && !served;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) served <= 1'b0;
    else        served <= bar_req && (served || bar_done);
  end
endmodule

// File: rtl/strict_order_gate.sv
module strict_order_gate
  import so_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 3,
  parameter int BW = 4,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [SW-1:0] req_size,
  input  logic [BW-1:0] req_beats,
  input  logic          req_write,
  input  logic          req_strict,
  input  logic          req_cacheable,
  input  logic          req_shared,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output logic [SW-1:0] bus_size,
  output logic [BW-1:0] bus_beats,
  output logic          bus_write,
  output logic          bus_cacheable,
  output logic          bus_shared,
  input  logic          rsp_valid,
  input  logic          rsp_err,
  input  logic          bar_req,
  output logic          bar_done,
  input  logic          irqm_req,
  output logic          irqm_stall,
  output logic          ord_stall,
  output logic          so_err,
  output logic          page_xing
);
  logic [CW-1:0] out_cnt;
  logic          so_busy;
  logic          cnt_zero;
  logic          cnt_full;
  logic          open;
  logic          issue;
  logic          span_x;
  gate_e         gstate;

  so_track #(.CW(CW)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue        (issue),
    .issue_strict (req_strict),
    .rsp_valid    (rsp_valid),
    .cnt          (out_cnt),
    .busy         (so_busy),
    .cnt_zero     (cnt_zero),
    .cnt_full     (cnt_full)
  );

  so_gate u_gate (
    .req_strict (req_strict),
    .busy       (so_busy),
    .cnt_zero   (cnt_zero),
    .cnt_full   (cnt_full),
    .state      (gstate)
  );

  so_page_xing #(.AW(AW), .SW(SW), .BW(BW)) u_xing (
    .addr  (req_addr),
    .size  (req_size),
    .beats (req_beats),
    .xing  (span_x)
  );

  so_barrier u_bar (
    .clk      (clk),
    .rst_n    (rst_n),
    .bar_req  (bar_req),
    .idle     (cnt_zero && !so_busy),
    .bar_done (bar_done)
  );

  assign open      = (gstate == GATE_OPEN);
  assign bus_valid = req_valid && open;
  assign req_ready = bus_ready && open;
  assign issue     = req_valid && req_ready;
  assign ord_stall = req_valid && !open;

  assign bus_addr      = req_addr;
  assign bus_size      = req_size;
  assign bus_beats     = req_beats;
  assign bus_write     = req_write;
  assign bus_cacheable = req_cacheable && !req_strict;
  assign bus_shared    = req_shared || req_strict;

  assign irqm_stall = irqm_req && so_busy;
  assign so_err     = rsp_valid && rsp_err && so_busy;
  assign page_xing  = issue && req_strict && span_x;
endmodule

// File: rtl/so_gate_checker.sv
module so_gate_checker #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_strict,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_shared,
  input logic          bus_cacheable,
  input logic          rsp_valid,
  input logic          bar_done,
  input logic          irqm_req,
  input logic          irqm_stall,
  input logic          so_err,
  input logic          so_busy,
  input logic [CW-1:0] out_cnt
);
  a_r3_drained_before_strict: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && req_strict) |-> (out_cnt == '0));

  a_r4_fence_blocks_bus: assert property (@(posedge clk) disable iff (!rst_n)
    so_busy |-> !bus_valid);

  a_r5_response_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (so_busy && rsp_valid) |=> !so_busy);

  a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done |=> !bar_done);

  a_r6_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done |-> (out_cnt == '0 && !so_busy));

  a_r7_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irqm_req && so_busy) |-> irqm_stall);

  a_r8_no_replay: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_strict && bus_valid && bus_ready) |=> !bus_valid);

  a_r9_strict_attrs: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && req_strict) |-> (bus_shared && !bus_cacheable));

  a_r11_err_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    so_err |-> (rsp_valid && so_busy));
endmodule

bind strict_order_gate so_gate_checker #(.CW(CW)) u_chk (.*);

// File: tb/tb_strict_order_gate.sv
module tb_strict_order_gate;
  localparam int PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 3;
  localparam int BW = 4;
  localparam int CW = 4;
  localparam int NV = 16;

  // {tag, rv st wr br rsp err bar irq big, rdy bv ost bd ims se xg}
  localparam logic [19:0] VEC [NV] = '{
    {4'd6,  9'b000100100, 7'b1001000},  // R6 barrier idle -> pulse
    {4'd6,  9'b000100100, 7'b1000000},  // R6 held -> no second pulse
    {4'd2,  9'b100100000, 7'b1100000},  // R2 plain issue
    {4'd3,  9'b110100100, 7'b0010000},  // R3 strict waits, barrier waits
    {4'd3,  9'b110110100, 7'b0010000},  // R3 draining response
    {4'd10, 9'b110100001, 7'b1100001},  // R10 strict crossing issue
    {4'd4,  9'b100100110, 7'b0010100},  // R4 R7 plain fenced
    {4'd4,  9'b110100000, 7'b0010000},  // R4 strict fenced
    {4'd5,  9'b100110010, 7'b0010100},  // R5 response cycle
    {4'd5,  9'b100100010, 7'b1100000},  // R5 released
    {4'd5,  9'b000010000, 7'b0000000},  // R5 drain
    {4'd8,  9'b110000000, 7'b0100000},  // R8 bus back-pressure
    {4'd8,  9'b111100000, 7'b1100000},  // R8 strict write issue
    {4'd11, 9'b000011000, 7'b0000010},  // R11 error response
    {4'd11, 9'b100100000, 7'b1100000},  // R11 released
    {4'd11, 9'b000010000, 7'b0000000}   // R11 drain
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_size = 3'd2;
  logic [BW-1:0] req_beats = 4'd1;
  logic          req_write = 1'b0, req_strict = 1'b0;
  logic          req_cacheable = 1'b1, req_shared = 1'b0;
  logic          bus_valid, bus_ready = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [SW-1:0] bus_size;
  logic [BW-1:0] bus_beats;
  logic          bus_write, bus_cacheable, bus_shared;
  logic          rsp_valid = 1'b0, rsp_err = 1'b0;
  logic          bar_req = 1'b0, bar_done;
  logic          irqm_req = 1'b0, irqm_stall;
  logic          ord_stall, so_err, page_xing;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  strict_order_gate #(.AW(AW), .SW(SW), .BW(BW), .CW(CW)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    req_valid = 0; req_strict = 0; req_write = 0; bus_ready = 0;
    rsp_valid = 0; rsp_err = 0; bar_req = 0; irqm_req = 0;
    req_cacheable = 1; req_shared = 0; req_size = 3'd2; req_beats = 4'd1;
    req_addr = 32'h0000_1000;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_in();
    req_valid = 1; req_strict = 1; irqm_req = 1;
    #1;
    chk("R1 bar_done in reset", bar_done, 0);
    chk("R1 irqm_stall in reset", irqm_stall, 0);
    chk("R1 ord_stall in reset", ord_stall, 0);
    chk("R1 so_err in reset", so_err, 0);
    repeat (2) @(negedge clk);
    idle_in();
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {req_valid, req_strict, req_write, bus_ready, rsp_valid, rsp_err,
       bar_req, irqm_req} = VEC[i][15:8];
      if (VEC[i][7]) begin req_addr = 32'h0000_1FF8; req_beats = 4'd4; end
      else begin req_addr = 32'h0000_1000; req_beats = 4'd1; end
      #1;
      checks++;
      if ({req_ready, bus_valid, ord_stall, bar_done, irqm_stall, so_err, page_xing}
          !== VEC[i][6:0]) begin
        errors++;
        $display("FAIL R%0d vec %0d act %b exp %b", VEC[i][19:16], i,
                 {req_ready, bus_valid, ord_stall, bar_done, irqm_stall, so_err, page_xing},
                 VEC[i][6:0]);
      end
    end

    // R9 R8 R10: strict attributes, unchanged fields, no cross, no replay
    @(negedge clk);
    idle_in();
    req_valid = 1; req_strict = 1; bus_ready = 1;
    req_addr = 32'h2000_0040; req_size = 3'd3; req_beats = 4'd2;
    #1;
    chk("R9 strict cacheable", bus_cacheable, 0);
    chk("R9 strict shared", bus_shared, 1);
    chk("R8 addr", bus_addr, 32'h2000_0040);
    chk("R8 size", bus_size, 3);
    chk("R8 beats", bus_beats, 2);
    chk("R10 no crossing", page_xing, 0);
    @(negedge clk); #1;
    chk("R8 no replay", bus_valid, 0);
    @(negedge clk);
    idle_in(); rsp_valid = 1;
    @(negedge clk);
    idle_in();
    req_valid = 1; bus_ready = 1; req_beats = 4'd4; req_addr = 32'h0000_1FF8;
    #1;
    chk("R2 plain cacheable", bus_cacheable, 1);
    chk("R2 plain shared", bus_shared, 0);
    chk("R10 plain no flag", page_xing, 0);
    @(negedge clk);
    idle_in(); rsp_valid = 1;

    // R12: fill the counter
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      idle_in(); req_valid = 1; bus_ready = 1;
    end
    @(negedge clk); #1;
    chk("R12 full holds", ord_stall, 1);
    chk("R12 full no bus", bus_valid, 0);
    rsp_valid = 1;
    @(negedge clk);
    rsp_valid = 0; #1;
    chk("R12 released", req_ready, 1);
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      idle_in(); rsp_valid = 1;
    end

    // R1: reset mid-fence
    @(negedge clk);
    idle_in(); req_valid = 1; req_strict = 1; bus_ready = 1;
    @(negedge clk);
    idle_in(); req_valid = 1; bus_ready = 1; irqm_req = 1; #1;
    chk("R4 fence up", ord_stall, 1);
    rst_n = 0; #1;
    chk("R1 reset clears fence", ord_stall, 0);
    chk("R1 reset clears irqm", irqm_stall, 0);
    @(negedge clk);
    idle_in(); rst_n = 1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule